// File: doc/BRIEF.md
# Serial Receive/Transmit Status Flags with Smart-Card Mode

This block holds the status flags of an asynchronous serial transceiver that can also run in a smart-card mode. The bit shifter, baud timing and line drivers are outside the block. They report to it through single-cycle event strobes: a character has been received (with its data, parity bit and stop-bit level), the last bit of a character has left the transmitter, or the returned error line has been sampled. The block checks the parity of each received character against the selected odd or even setting. It keeps the receive data register and five status flags, and tells the shifters when reception and transmission must stall.

Software reads the flags as one status byte. A clearable flag drops only when a 0 is written to its bit after a read that saw that bit at 1. The transmit-end flag cannot be written. It sets when the transmitter runs dry and clears when new transmit data becomes valid. In smart-card mode the receiver may pull the line low to report a parity error. That is captured as the error-signal flag, and it also stops transmit-end from setting. In that mode framing errors are not checked.

Top module: `sci_status_flags`

## Requirements
- R1: Parity error is detected when the number of ones in the 8 data bits plus the parity bit is odd with `odd_par_i`=0 (even parity), or even with `odd_par_i`=1 (odd parity).
- R2: An accepted received character is always loaded into `rdr_o`. The data-full flag sets only if there is no parity error and no framing error. A parity error sets the parity-error flag instead.
- R3: While the parity-error flag is 1, `rx_block_o`=1 and received characters are dropped (`rdr_o` and the flags do not change). `tx_block_o`=1 only if the parity-error flag is set and `sync_mode_i`=1, and while it is 1 a transmit-done event does not set transmit-end.
- R4: In smart-card mode (`sc_mode_i`=1) with `tx_en_i`=1, an error-line sample (`err_smp_i`=1) that finds `err_line_i`=0 sets the error-signal flag.
- R5: In normal mode (`sc_mode_i`=0) the error-signal inputs are ignored, and the error-signal flag never sets.
- R6: A clearable flag (data-full, framing, error-signal, parity-error) clears only when `wr_i` writes 0 to its bit after a `rd_i` that returned it as 1. A write of 1, or a write of 0 with no such prior read, leaves it unchanged. Each write consumes the read marker.
- R7: If a flag's set condition and its qualifying clearing write fall in the same cycle, the flag stays 1.
- R8: Reset (`rst_ni`=0) and `standby_i`=1 clear all flags to 0.
- R9: Deasserting `rx_en_i` or `tx_en_i` does not change the parity-error or error-signal flags. With `tx_en_i`=0 the error line is not sampled.
- R10: In normal mode, transmit-end sets on `tx_done_i` when `tdr_valid_i`=0. It clears while `tdr_valid_i`=1, and writes have no effect on it.
- R11: In smart-card mode, transmit-end additionally needs the error-signal flag to be 0 and not setting in that cycle.
- R12: In normal mode a received stop bit of 0 (`rx_stop_i`=0) sets the framing flag. In smart-card mode the framing flag never sets.
- R13: `status_o` bit positions: data-full 6, framing 5, error-signal 4, parity-error 3, transmit-end 2. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Standby request, clears all flags |
| sc_mode_i | input | 1 | 1 = smart-card mode, 0 = normal mode |
| sync_mode_i | input | 1 | 1 = synchronous framing (parity error also stalls transmit) |
| odd_par_i | input | 1 | 1 = odd parity, 0 = even parity |
| rx_en_i | input | 1 | Receiver enable |
| tx_en_i | input | 1 | Transmitter enable |
| rx_done_i | input | 1 | Strobe: one character received |
| rx_data_i | input | 8 | Received data bits |
| rx_par_i | input | 1 | Received parity bit |
| rx_stop_i | input | 1 | Received stop-bit level |
| tx_done_i | input | 1 | Strobe: last bit of a character sent |
| tdr_valid_i | input | 1 | Transmit data register holds valid data |
| err_smp_i | input | 1 | Strobe: error line sampled this cycle |
| err_line_i | input | 1 | Sampled error-line level (0 = error) |
| rd_i | input | 1 | Status register read strobe |
| wr_i | input | 1 | Status register write strobe |
| wdata_i | input | 8 | Status write data |
| status_o | output | 8 | Status byte |
| rdr_o | output | 8 | Receive data register |
| rx_block_o | output | 1 | Reception stalled |
| tx_block_o | output | 1 | Transmission stalled |

## Verification
Every flag is a register that drives `status_o` directly. A wrong set, clear or read-marker state therefore shows in the status byte at the sample point right after the clock edge that caused it, and it stays visible until the flag is cleared. A lost or extra read marker shows only at the next write of 0. The bench therefore pairs reads with writes of 0, writes of 1 and writes without a prior read, and checks the byte after each one. A stuck parity-error flag shows at once on `rx_block_o`, and as a frozen `rdr_o` on the next received character.

// File: rtl/sci_flag_pkg.sv
package sci_flag_pkg;
  localparam int STAT_W = 8;
  localparam int N_CLR  = 4;

  // flag index into the clearable set
  localparam int F_RDRF = 0;
  localparam int F_FRM  = 1;
  localparam int F_ERS  = 2;
  localparam int F_PER  = 3;

  // status byte positions
  localparam int POS_RDRF = 6;
  localparam int POS_FRM  = 5;
  localparam int POS_ERS  = 4;
  localparam int POS_PER  = 3;
  localparam int POS_TEND = 2;

  localparam int CLR_POS [N_CLR] = '{POS_RDRF, POS_FRM, POS_ERS, POS_PER};
endpackage

// File: rtl/sci_parity_chk.sv
module sci_parity_chk #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  input  logic              odd_i,
  output logic              err_o
);
  // odd total count with even setting, or even total with odd setting
  assign err_o = (^{data_i, par_i}) ^ odd_i;
endmodule

// File: rtl/sci_clr_flag.sv
module sci_clr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic standby_i,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, seen_q, clr;

  assign clr = wr_i & ~wbit_i & seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (standby_i) begin
      flag_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      if (set_i)    flag_q <= 1'b1;   // set beats clear
      else if (clr) flag_q <= 1'b0;
      seen_q <= (seen_q & ~wr_i) | (rd_i & flag_q);
    end
  end

  assign flag_o = flag_q;

  AST_CLR_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) && !$past(standby_i) |-> $past(wr_i) && !$past(wbit_i)) // R6
    else $error("flag cleared without write of 0");
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && !standby_i |=> flag_q) // R7
    else $error("set lost");
  AST_STANDBY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> !flag_q) // R8
    else $error("standby did not clear");
endmodule

// File: rtl/sci_tend_flag.sv
module sci_tend_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic standby_i,
  input  logic sc_mode_i,
  input  logic tx_done_i,
  input  logic tdr_valid_i,
  input  logic tx_block_i,
  input  logic ers_i,
  input  logic ers_set_i,
  output logic tend_o
);
  logic tend_q, set;

  assign set = tx_done_i & ~tdr_valid_i & ~tx_block_i
             & (~sc_mode_i | ~(ers_i | ers_set_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          tend_q <= 1'b0;
    else if (standby_i)   tend_q <= 1'b0;
    else if (set)         tend_q <= 1'b1;
    else if (tdr_valid_i) tend_q <= 1'b0;
  end

  assign tend_o = tend_q;

  AST_TEND_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tend_q) |-> $past(tx_done_i) && !$past(tdr_valid_i)) // R10
    else $error("transmit-end rose without event");
  AST_TEND_SC_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_mode_i && ers_i && !tend_q |=> !tend_q) // R11
    else $error("transmit-end set despite error signal");
endmodule

// File: rtl/sci_status_flags.sv
module sci_status_flags
  import sci_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              standby_i,
  input  logic              sc_mode_i,
  input  logic              sync_mode_i,
  input  logic              odd_par_i,
  input  logic              rx_en_i,
  input  logic              tx_en_i,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_par_i,
  input  logic              rx_stop_i,
  input  logic              tx_done_i,
  input  logic              tdr_valid_i,
  input  logic              err_smp_i,
  input  logic              err_line_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] status_o,
  output logic [DATA_W-1:0] rdr_o,
  output logic              rx_block_o,
  output logic              tx_block_o
);
  logic [N_CLR-1:0]  set_v, flag_v;
  logic [DATA_W-1:0] rdr_q;
  logic              par_err, rx_acc, frm_err, tend, tx_block;

  sci_parity_chk #(.DATA_W(DATA_W)) u_par (
    .data_i (rx_data_i),
    .par_i  (rx_par_i),
    .odd_i  (odd_par_i),
    .err_o  (par_err)
  );

  assign rx_acc   = rx_done_i & rx_en_i & ~flag_v[F_PER];
  assign frm_err  = ~sc_mode_i & ~rx_stop_i;
  assign tx_block = flag_v[F_PER] & sync_mode_i;

  assign set_v[F_RDRF] = rx_acc & ~par_err & ~frm_err;
  assign set_v[F_FRM]  = rx_acc & frm_err;
  assign set_v[F_ERS]  = sc_mode_i & tx_en_i & err_smp_i & ~err_line_i;
  assign set_v[F_PER]  = rx_acc & par_err;

  for (genvar g = 0; g < N_CLR; g++) begin : g_flag
    sci_clr_flag u_flag (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .standby_i (standby_i),
      .set_i     (set_v[g]),
      .rd_i      (rd_i),
      .wr_i      (wr_i),
      .wbit_i    (wdata_i[CLR_POS[g]]),
      .flag_o    (flag_v[g])
    );
  end

  sci_tend_flag u_tend (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .standby_i   (standby_i),
    .sc_mode_i   (sc_mode_i),
    .tx_done_i   (tx_done_i),
    .tdr_valid_i (tdr_valid_i),
    .tx_block_i  (tx_block),
    .ers_i       (flag_v[F_ERS]),
    .ers_set_i   (set_v[F_ERS]),
    .tend_o      (tend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdr_q <= '0;
    else if (rx_acc) rdr_q <= rx_data_i;
  end

  always_comb begin
    status_o = '0;
    for (int i = 0; i < N_CLR; i++) status_o[CLR_POS[i]] = flag_v[i];
    status_o[POS_TEND] = tend;
  end

  assign rdr_o      = rdr_q;
  assign rx_block_o = flag_v[F_PER];
  assign tx_block_o = tx_block;

  AST_PER_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_i && rx_en_i && !status_o[POS_PER] && par_err |=> rdr_o == $past(rx_data_i)) // R2
    else $error("parity-error byte not stored");
  AST_PER_NO_RDRF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_i && rx_en_i && !status_o[POS_PER] && par_err && !status_o[POS_RDRF] |=> !status_o[POS_RDRF]) // R2
    else $error("data-full set on parity error");
  AST_RX_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[POS_PER] && rx_done_i |=> $stable(rdr_o)) // R3
    else $error("reception not blocked");
  AST_ERS_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sc_mode_i && !status_o[POS_ERS] |=> !status_o[POS_ERS]) // R5
    else $error("error-signal set in normal mode");
  AST_NO_FRM_SC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_mode_i && !status_o[POS_FRM] |=> !status_o[POS_FRM]) // R12
    else $error("framing flag set in smart-card mode");
endmodule

// File: tb/sci_status_flags_bench.sv
`timescale 1ns/1ps
module sci_status_flags_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic standby = 0, sc = 0, sync_m = 0, odd = 0, rx_en = 1, tx_en = 1;
  logic rxd = 0, par = 0, stp = 1, txd = 0, tdv = 0, es = 0, el = 1, rd = 0, wr = 0;
  logic [7:0] dat = 0, wd = 0, st, rdr;
  logic rxb, txb;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sci_status_flags u_sci_status_flags (
    .clk_i(clk), .rst_ni(rst_n), .standby_i(standby), .sc_mode_i(sc),
    .sync_mode_i(sync_m), .odd_par_i(odd), .rx_en_i(rx_en), .tx_en_i(tx_en),
    .rx_done_i(rxd), .rx_data_i(dat), .rx_par_i(par), .rx_stop_i(stp),
    .tx_done_i(txd), .tdr_valid_i(tdv), .err_smp_i(es), .err_line_i(el),
    .rd_i(rd), .wr_i(wr), .wdata_i(wd), .status_o(st), .rdr_o(rdr),
    .rx_block_o(rxb), .tx_block_o(txb));

  typedef struct packed {
    logic sc, odd, rxd; logic [7:0] dat;
    logic par, stp, txd, tdv, es, el, rd, wr;
    logic [7:0] wd, est, erd;
  } vec_t;
  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b1,8'h35,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'h40,8'h35}, // R2 ok even
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,8'h40,8'h35}, // R6 read
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,8'h00,8'h00,8'h35}, // R6 clear
    '{1'b0,1'b0,1'b1,8'h07,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'h08,8'h07}, // R1 R2 parity err
    '{1'b0,1'b0,1'b1,8'hAA,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'h08,8'h07}, // R3 blocked
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,8'h00,8'h08,8'h07}, // R6 no read
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,8'h08,8'h07},
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,8'h08,8'h08,8'h07}, // R6 write 1
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,8'h08,8'h07},
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,8'h00,8'h00,8'h07}, // R6
    '{1'b0,1'b1,1'b1,8'h07,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'h40,8'h07}, // R1 odd ok
    '{1'b0,1'b1,1'b1,8'h03,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'h48,8'h03}, // R1 odd err
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,8'h48,8'h03},
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,8'h00,8'h00,8'h03},
    '{1'b0,1'b0,1'b1,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'h20,8'h00}, // R12 framing
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,8'h20,8'h00},
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,8'h00,8'h00,8'h00},
    '{1'b1,1'b0,1'b1,8'h01,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'h40,8'h01}, // R12 sc no frm
    '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'h44,8'h01}, // R11 tend sc
    '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,8'h50,8'h01}, // R4 R10
    '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'h50,8'h01}, // R11 held
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,8'h50,8'h01}, // R5
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,8'h50,8'h01},
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,8'h00,8'h00,8'h01}, // R6 two flags
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,8'h01}, // R5 ignored
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'h04,8'h01}, // R10 tend
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,8'h00,8'h04,8'h01}, // R10 ro
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,8'h04,8'h01},
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,8'h00,8'h04,8'h01}  // R10 ro
  };

  task automatic tick();
    @(posedge clk); @(negedge clk);
    rxd = 0; txd = 0; es = 0; el = 1; rd = 0; wr = 0; wd = 0; stp = 1; par = 0;
  endtask

  task automatic chk(string req, logic [7:0] est, logic [7:0] erd);
    vectors++;
    if (st !== est || rdr !== erd) begin
      miscompares++;
      $display("FAIL %s: status=%02h rdr=%02h expected status=%02h rdr=%02h", req, st, rdr, est, erd);
    end
  endtask

  task automatic chk_bit(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset", 8'h00, 8'h00);
    chk_bit("R3 reset rx_block", rxb, 1'b0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      sc = VEC[i].sc; odd = VEC[i].odd; rxd = VEC[i].rxd; dat = VEC[i].dat;
      par = VEC[i].par; stp = VEC[i].stp; txd = VEC[i].txd; tdv = VEC[i].tdv;
      es = VEC[i].es; el = VEC[i].el; rd = VEC[i].rd; wr = VEC[i].wr; wd = VEC[i].wd;
      tick();
      chk($sformatf("R13 vector %0d", i), VEC[i].est, VEC[i].erd);
    end
    sc = 0; odd = 0; tdv = 0;
    // R7 set beats clearing write
    rxd = 1; dat = 8'h00; tick(); chk("R2 rx ok", 8'h44, 8'h00);
    rd = 1; tick(); chk("R7 read", 8'h44, 8'h00);
    wr = 1; wd = 8'h00; rxd = 1; dat = 8'h11; tick(); chk("R7 set wins", 8'h44, 8'h11);
    // R3 transmit blocking
    tdv = 1; tick(); tdv = 0; chk("R10 tdr clears tend", 8'h40, 8'h11);
    rxd = 1; dat = 8'h01; tick(); chk("R3 per set", 8'h48, 8'h01);
    chk_bit("R3 rx_block", rxb, 1'b1);
    chk_bit("R3 tx_block async", txb, 1'b0);
    sync_m = 1; #1; chk_bit("R3 tx_block sync", txb, 1'b1);
    txd = 1; tick(); chk("R3 tend held off", 8'h48, 8'h01);
    sync_m = 0;
    // R9 enables do not touch flags
    rx_en = 0; tx_en = 0; sc = 1; es = 1; el = 0; tick();
    chk("R9 disabled", 8'h48, 8'h01);
    rx_en = 1; tx_en = 1; sc = 0;
    // R8 standby
    standby = 1; tick(); standby = 0; chk("R8 standby", 8'h00, 8'h01);
    chk_bit("R8 rx_block after standby", rxb, 1'b0);
    // R8 reset mid-run
    rxd = 1; dat = 8'h35; tick(); chk("R2 rx", 8'h40, 8'h35);
    rst_n = 0; #1; chk("R8 async reset", 8'h00, 8'h00);
    @(negedge clk); rst_n = 1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule